// File: doc/BRIEF.md
# Pulse Voice Duty Sequencer

This block produces the one-bit square waveform of a single pulse voice in a retro sound generator. It contains an 11-bit period timer that counts down, a 3-bit step counter that also counts down, and a duty table. The duty table turns the current step position and the selected duty into the output level.

The timer decrements only in cycles where the half-rate enable is high. When the timer is at zero in such a cycle, it reloads the programmed period and the step counter moves one position down. A write to the period-high register sends the step counter back to position 0 at once and leaves the timer count untouched. The phase of the first waveform step after that write therefore depends only on where the timer happened to be.

The block has no data stream, so it has no valid/ready pair and applies no back-pressure. Every register write strobe takes effect in the clock cycle in which it is sampled. The output is a plain level that is valid in every cycle.

Top module: `pulse_duty_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, the duty, period, timer count and step are all 0 and `wave` is 0.
- R2: The timer changes only in cycles where `half_en` is high. In such a cycle it decrements, or it reloads the period when it is at 0. With `half_en` high every second clock, the step advances once every 2×(P+1) clocks for period P (224 clocks for P = 111).
- R3: Each timer expiry moves the step counter down by one, so the positions run 0, 7, 6, 5, 4, 3, 2, 1 and then repeat.
- R4: A `wr_duty` write loads the duty from `wr_data[1:0]`. Read in counting order starting at position 0, the output patterns are: duty 0 → 01000000, duty 1 → 01100000, duty 2 → 01111000, duty 3 → 10011111.
- R5: A `wr_hi` write loads period bits 10:8 from `wr_data[2:0]` and sets the step to 0. `wave` shows position 0 in the very next cycle, without waiting for a timer expiry.
- R6: A `wr_hi` write neither reloads nor clears the timer. The count keeps decrementing from its current value.
- R7: `wr_duty` and `wr_lo` writes never move the step counter.
- R8: A duty change is visible on `wave` in the cycle after the write, and the step position does not change.
- R9: When a `wr_hi` write coincides with a timer expiry, the step becomes 0, not 0 minus 1.
- R10: A `wr_lo` write loads period bits 7:0 from `wr_data`. The new period is first used at the next reload, and the running count is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_en | input | 1 | Timer clock enable, normally high every second clock |
| wr_duty | input | 1 | Duty register write strobe |
| wr_lo | input | 1 | Period low byte write strobe |
| wr_hi | input | 1 | Period high bits write strobe; restarts the step counter |
| wr_data | input | 8 | Write data for all three strobes |
| wave | output | 1 | Square waveform level |

## Verification
The bench places period-high writes at every phase of a short timer count, including the exact expiry cycle. A design that reloaded the timer on restart would push the first step late. A design that applied the restart only at the next expiry would hold the old level for a whole step. A design that let the expiry win in the coinciding case would start the pass at position 7. Duty and period-low writes arrive in the middle of steps, which exposes any design that restarts on them or delays the new pattern. Sweeping every duty over several periods catches an up-counting step or a mirrored table, because either one makes every pattern come out shifted or reversed.

// File: rtl/psq_pkg.sv
package psq_pkg;
  localparam int PERIOD_W = 11;
  localparam int STEP_W   = 3;
  localparam int N_STEPS  = 1 << STEP_W;
  localparam int DUTY_W   = 2;
  localparam int LO_W     = 8;
  localparam int HI_W     = PERIOD_W - LO_W;

  typedef logic [PERIOD_W-1:0] period_t;
  typedef logic [STEP_W-1:0]   step_t;
  typedef logic [DUTY_W-1:0]   duty_t;

  // Bit p of the result is the level at step position p.
  function automatic logic [N_STEPS-1:0] duty_mask(input duty_t d);
    case (d)
      2'd0:    return 8'b1000_0000;
      2'd1:    return 8'b1100_0000;
      2'd2:    return 8'b1111_0000;
      default: return 8'b0011_1111;
    endcase
  endfunction
endpackage

// File: rtl/psq_regs.sv
module psq_regs
  import psq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_duty,
  input  logic       wr_lo,
  input  logic       wr_hi,
  input  logic [7:0] wr_data,
  output duty_t      duty,
  output period_t    period
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty   <= '0;
      period <= '0;
    end else begin
      if (wr_duty) duty <= wr_data[DUTY_W-1:0];
      if (wr_lo)   period[LO_W-1:0] <= wr_data[LO_W-1:0];
      if (wr_hi)   period[PERIOD_W-1:LO_W] <= wr_data[HI_W-1:0];
    end
  end
endmodule

// File: rtl/psq_timer.sv
module psq_timer
  import psq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    half_en,
  input  period_t period,
  output period_t count,
  output logic    expire
);
  assign expire = half_en && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (expire)  count <= period;
    else if (half_en) count <= count - 1'b1;
  end
endmodule

// File: rtl/psq_step.sv
module psq_step
  import psq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart,
  input  logic  expire,
  output step_t step
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      step <= '0;
    else if (restart) step <= '0;
    else if (expire)  step <= step - 1'b1;
  end
endmodule

// File: rtl/psq_duty_table.sv
module psq_duty_table
  import psq_pkg::*;
(
  input  duty_t duty,
  input  step_t step,
  output logic  level
);
  logic [N_STEPS-1:0] row;
  logic [N_STEPS-1:0] mask;

  assign mask = duty_mask(duty);

  for (genvar p = 0; p < N_STEPS; p++) begin : g_pos
    assign row[p] = mask[p] && (step == step_t'(p));
  end

  assign level = |row;
endmodule

// File: rtl/pulse_duty_seq.sv
module pulse_duty_seq
  import psq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       half_en,
  input  logic       wr_duty,
  input  logic       wr_lo,
  input  logic       wr_hi,
  input  logic [7:0] wr_data,
  output logic       wave
);
  duty_t   duty_q;
  period_t period_q;
  period_t timer_q;
  step_t   step_q;
  logic    expire;

  psq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_duty(wr_duty), .wr_lo(wr_lo),
    .wr_hi(wr_hi), .wr_data(wr_data), .duty(duty_q), .period(period_q)
  );

  psq_timer u_timer (
    .clk(clk), .rst_n(rst_n), .half_en(half_en), .period(period_q),
    .count(timer_q), .expire(expire)
  );

  psq_step u_step (
    .clk(clk), .rst_n(rst_n), .restart(wr_hi), .expire(expire), .step(step_q)
  );

  psq_duty_table u_table (
    .duty(duty_q), .step(step_q), .level(wave)
  );
endmodule

// File: rtl/psq_checker.sv
module psq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        half_en,
  input logic        wr_duty,
  input logic        wr_lo,
  input logic        wr_hi,
  input logic [10:0] period,
  input logic [10:0] timer,
  input logic [2:0]  step,
  input logic [1:0]  duty,
  input logic        wave
);
  p_timer_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !half_en |=> $stable(timer));

  p_timer_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (half_en && timer == 11'd0) |=> timer == $past(period));

  p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (half_en && timer == 11'd0 && !wr_hi) |=> step == $past(step) - 3'd1);

  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> step == 3'd0);

  p_timer_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && half_en && timer != 11'd0) |=> timer == $past(timer) - 11'd1);

  p_step_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hi && !(half_en && timer == 11'd0)) |=> $stable(step));

  p_duty0_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == 2'd0) |-> wave == (step == 3'd7));

  always_comb begin
    if (!rst_n) a_reset_out_r1: assert (wave == 1'b0);
  end
endmodule

bind pulse_duty_seq psq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .half_en(half_en), .wr_duty(wr_duty),
  .wr_lo(wr_lo), .wr_hi(wr_hi), .period(period_q), .timer(timer_q),
  .step(step_q), .duty(duty_q), .wave(wave)
);

// File: tb/sim_pulse_duty_seq.sv
`timescale 1ns/1ps
module sim_pulse_duty_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic half_en = 1'b0;
  logic wr_duty = 1'b0, wr_lo = 1'b0, wr_hi = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic wave;

  int checks = 0;
  int errors = 0;

  // Reference state, kept from the requirement text only.
  int m_duty = 0, m_per = 0, m_tmr = 0, m_pos = 0;

  always #10 clk = ~clk;

  pulse_duty_seq u0 (
    .clk(clk), .rst_n(rst_n), .half_en(half_en), .wr_duty(wr_duty),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .wave(wave)
  );

  // Patterns in counting order (first char = position 0), per R4.
  function automatic logic exp_level(int d, int pos);
    string pat;
    int k;
    case (d)
      0: pat = "01000000";
      1: pat = "01100000";
      2: pat = "01111000";
      default: pat = "10011111";
    endcase
    k = (8 - pos) % 8;
    return pat[k] == "1";
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t wave=%0b expected=%0b", req, $time, act, exp);
    end
  endtask

  // One clock: drive strobes, update the model at the edge, compare after.
  task automatic cyc(string req, bit wd, bit wl, bit wh, logic [7:0] d);
    bit he;
    bit expd;
    he = ~half_en;
    half_en = he; wr_duty = wd; wr_lo = wl; wr_hi = wh; wr_data = d;
    @(posedge clk);
    expd = he && (m_tmr == 0);
    if (expd) m_tmr = m_per;
    else if (he) m_tmr = m_tmr - 1;
    if (wh) m_pos = 0;
    else if (expd) m_pos = (m_pos + 7) % 8;
    if (wd) m_duty = d[1:0];
    if (wl) m_per = (m_per & 32'h700) | d;
    if (wh) m_per = (m_per & 32'h0FF) | (int'(d[2:0]) << 8);
    @(negedge clk);
    wr_duty = 1'b0; wr_lo = 1'b0; wr_hi = 1'b0;
    check(req, wave, exp_level(m_duty, m_pos));
  endtask

  task automatic idle(string req, int n);
    for (int i = 0; i < n; i++) cyc(req, 0, 0, 0, 8'h00);
  endtask

  task automatic set_period(int p);
    cyc("R10", 0, 1, 0, 8'(p & 255));
    cyc("R5", 0, 0, 1, 8'(p >> 8));
  endtask

  int periods[6] = '{0, 1, 2, 3, 7, 111};

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", wave, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", wave, 1'b0);
    idle("R1", 4);

    // R2 R3 R4: every duty over several periods, full passes
    for (int d = 0; d < 4; d++) begin
      for (int i = 0; i < 6; i++) begin
        cyc("R4", 1, 0, 0, 8'(d));
        set_period(periods[i]);
        idle("R2 R3 R4", 16 * (periods[i] + 1) + 6);
      end
    end

    // R5 R6 R9: restart at every phase of a short count
    cyc("R4", 1, 0, 0, 8'd2);
    set_period(5);
    for (int ph = 0; ph < 14; ph++) begin
      idle("R6", ph);
      cyc("R5 R9", 0, 0, 1, 8'd0);
      idle("R5 R6", 40);
    end

    // R8 R7: duty changes mid-step, never moving the step
    set_period(9);
    for (int i = 0; i < 40; i++) begin
      cyc("R8 R7", 1, 0, 0, 8'(i % 4));
      idle("R8", 2);
    end

    // R10 R7: low-byte writes mid-count, used at the next reload only
    cyc("R4", 1, 0, 0, 8'd1);
    for (int i = 0; i < 12; i++) begin
      cyc("R10 R7", 0, 1, 0, 8'(3 + 2 * i));
      idle("R10", 11 + i);
    end

    // Large period with upper bits, then restart mid-count
    set_period(11'h2A5);
    idle("R2", 700);
    cyc("R5 R6", 0, 0, 1, 8'd0);
    set_period(3);
    idle("R3", 80);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule